// File: doc/BRIEF.md
# External Interrupt Request Unit

This block conditions the two external interrupt pins of a CPU. One pin carries a maskable request. The other carries a non-maskable request. Both pins are active low and may change at any time. Each pin passes through a chain of synchronizer flops. A falling-edge detector then watches the synchronized level. The block applies the enable, trigger-mode and mask rules and drives one request line per pin toward the CPU.

The maskable request has a small configuration register. One bit turns the request on. The other bit selects between low-level triggering and falling-edge triggering. The CPU's own interrupt mask bit comes in as an input and gates the request with no delay. In edge mode a pending latch holds the event until the CPU acknowledges it. Clearing the enable bit withdraws the request and empties that latch.

The non-maskable request is blocked by its own mask bit, which reset sets. Software may clear that mask once. After that, nothing short of reset can set it again. Edges that arrive on the pin while the mask is set are dropped.

Top module: `xint_ctrl`

## Requirements
- R1: Right after reset, the configuration reads back with enable 0, level mode and the non-maskable mask set, which is `cfg_rdata` = 3'b100. Both request outputs are low.
- R2: `irq_req` can be high only while enable is 1 and `cpu_imask` is 0. A change of `cpu_imask` acts on `irq_req` within the same cycle.
- R3: In level mode (`cfg_wdata[1]` = 0), with the request enabled and unmasked, `irq_req` follows the inverted pin level two clock edges after the pin changes. No latch is kept in this mode.
- R4: In edge mode (`cfg_wdata[1]` = 1), with the request enabled, a high-to-low transition of the pin sets a pending latch at the third clock edge after the pin falls. The latch stays set until it is cleared.
- R5: A one-cycle `irq_ack` clears the maskable pending latch. If a new falling edge is detected in that same cycle, the latch stays set.
- R6: A configuration write with `cfg_wdata[0]` = 0 drops `irq_req` in the cycle that follows the write. It also empties the pending latch, so enabling again does not bring back the old request.
- R7: While the non-maskable mask is set, `nmi_req` stays low. Falling edges seen during that time are discarded and do not appear after unmasking.
- R8: An `nm_wr` with `nm_wdata` = 0 clears the non-maskable mask. An `nm_wr` with `nm_wdata` = 1 is ignored. Only reset sets the mask again.
- R9: With the mask clear, a falling edge on `nmi_pin_n` raises `nmi_req` at the third clock edge after the pin falls. `nmi_req` stays high until an `nmi_ack` pulse clears it. A falling edge detected in the same cycle as the acknowledge wins.
- R10: `cfg_rdata` bit 0 is the enable, bit 1 is the trigger mode (1 = falling edge), and bit 2 is the non-maskable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_n | input | 1 | Maskable request pin, active low, asynchronous |
| nmi_pin_n | input | 1 | Non-maskable request pin, active low, asynchronous |
| cpu_imask | input | 1 | CPU interrupt mask bit; 1 blocks the maskable request |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 2 | Bit 0: enable. Bit 1: trigger mode (1 = falling edge) |
| nm_wr | input | 1 | Write strobe for the non-maskable mask |
| nm_wdata | input | 1 | Mask value; only 0 takes effect |
| irq_ack | input | 1 | One-cycle acknowledge for the maskable request |
| nmi_ack | input | 1 | One-cycle acknowledge for the non-maskable request |
| irq_req | output | 1 | Maskable request to the CPU |
| nmi_req | output | 1 | Non-maskable request to the CPU |
| cfg_rdata | output | 3 | Read-back: enable, trigger mode, non-maskable mask |

## Verification
The embedded properties assume the following about the block's inputs:
- The write strobes and acknowledges are synchronous to `clk` and each lasts one cycle per event.
- Only the two pins are free-running.
- The synchronizer check relies on the chain resetting to the idle high level, so the input seen before reset ends is never propagated.

The stimulus changes every input half a cycle away from the active edge. Writes and acknowledges last exactly one cycle. Random pin activity is held for several cycles at a time, so edges in both trigger modes reach the latches rather than being filtered away.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    localparam int unsigned CFG_W         = 3;
    localparam int unsigned CFG_EN_BIT    = 0;
    localparam int unsigned CFG_TRIG_BIT  = 1;
    localparam int unsigned CFG_NMASK_BIT = 2;
    localparam int unsigned CFG_WR_W      = CFG_NMASK_BIT;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  enable;
    } mcfg_t;

    localparam mcfg_t MCFG_RESET = '{trig: TRIG_LEVEL, enable: 1'b0};

    // Active-low pin: an event is a 1 -> 0 step of the synchronized level
    function automatic logic is_fall(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

    function automatic mcfg_t unpack_cfg(input logic [CFG_WR_W-1:0] wd);
        mcfg_t c;
        c.enable = wd[CFG_EN_BIT];
        c.trig   = trig_e'(wd[CFG_TRIG_BIT]);
        return c;
    endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned STAGES = xint_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Reset to the idle (high) level so no false edge follows reset
    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end

            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
                chain[i] == $past(chain[i-1])); // R3
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/xint_cfg.sv
module xint_cfg
    import xint_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_WR_W-1:0] cfg_wdata,
    input  logic                nm_wr,
    input  logic                nm_wdata,
    output mcfg_t               mcfg,
    output logic                nm_mask
);
    mcfg_t mcfg_q;
    logic  nm_mask_q;

    always_ff @(posedge clk) begin
        if (rst)         mcfg_q <= MCFG_RESET;
        else if (cfg_wr) mcfg_q <= unpack_cfg(cfg_wdata);
    end

    // The mask only moves toward 0; a written 1 has no path to the flop
    always_ff @(posedge clk) begin
        if (rst)                    nm_mask_q <= 1'b1;
        else if (nm_wr && !nm_wdata) nm_mask_q <= 1'b0;
    end

    assign mcfg    = mcfg_q;
    assign nm_mask = nm_mask_q;

    AST_NM_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
        !nm_mask_q |=> !nm_mask_q); // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(mcfg_q)); // R10

endmodule

// File: rtl/xint_mask_path.sv
module xint_mask_path
    import xint_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_lvl,
    input  mcfg_t mcfg,
    input  logic  cpu_imask,
    input  logic  ack,
    output logic  req
);
    logic prev_lvl;
    logic pend;
    logic fall;
    logic gate;
    logic raw;

    assign fall = is_fall(prev_lvl, pin_lvl);

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= pin_lvl;
    end

    // The latch is live only while enabled in edge mode; a new edge wins over ack
    always_ff @(posedge clk) begin
        if (rst)                                      pend <= 1'b0;
        else if (!mcfg.enable || mcfg.trig == TRIG_LEVEL) pend <= 1'b0;
        else if (fall)                                pend <= 1'b1;
        else if (ack)                                 pend <= 1'b0;
    end

    always_comb begin
        gate = mcfg.enable & ~cpu_imask;
        unique case (mcfg.trig)
            TRIG_FALL:  raw = pend;
            TRIG_LEVEL: raw = ~pin_lvl;
            default:    raw = 1'b0;
        endcase
        req = gate & raw;
    end

    AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        !mcfg.enable |=> !pend); // R6
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pend && mcfg.enable && mcfg.trig == TRIG_FALL && !ack) |=> pend); // R4
    AST_FALL_WINS: assert property (@(posedge clk) disable iff (rst)
        (fall && ack && mcfg.enable && mcfg.trig == TRIG_FALL) |=> pend); // R5
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cpu_imask |-> !req); // R2

endmodule

// File: rtl/xint_nm_path.sv
module xint_nm_path
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_lvl,
    input  logic nm_mask,
    input  logic ack,
    output logic req
);
    logic prev_lvl;
    logic pend;
    logic fall;

    assign fall = is_fall(prev_lvl, pin_lvl);

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= pin_lvl;
    end

    // Events seen while masked are dropped, not stored
    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (nm_mask) pend <= 1'b0;
        else if (fall)    pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    assign req = pend & ~nm_mask;

    AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        nm_mask |=> !pend); // R7
    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack && !nm_mask) |=> pend); // R9

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_pin_n,
    input  logic                nmi_pin_n,
    input  logic                cpu_imask,
    input  logic                cfg_wr,
    input  logic [CFG_WR_W-1:0] cfg_wdata,
    input  logic                nm_wr,
    input  logic                nm_wdata,
    input  logic                irq_ack,
    input  logic                nmi_ack,
    output logic                irq_req,
    output logic                nmi_req,
    output logic [CFG_W-1:0]    cfg_rdata
);
    logic  irq_lvl;
    logic  nmi_lvl;
    mcfg_t mcfg;
    logic  nm_mask;

    xint_sync #(.STAGES(SYNC_STAGES)) u_sync_irq (
        .clk(clk), .rst(rst), .d_async(irq_pin_n), .q_sync(irq_lvl)
    );

    xint_sync #(.STAGES(SYNC_STAGES)) u_sync_nmi (
        .clk(clk), .rst(rst), .d_async(nmi_pin_n), .q_sync(nmi_lvl)
    );

    xint_cfg u_cfg (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .nm_wr(nm_wr), .nm_wdata(nm_wdata),
        .mcfg(mcfg), .nm_mask(nm_mask)
    );

    xint_mask_path u_mpath (
        .clk(clk), .rst(rst), .pin_lvl(irq_lvl), .mcfg(mcfg),
        .cpu_imask(cpu_imask), .ack(irq_ack), .req(irq_req)
    );

    xint_nm_path u_npath (
        .clk(clk), .rst(rst), .pin_lvl(nmi_lvl), .nm_mask(nm_mask),
        .ack(nmi_ack), .req(nmi_req)
    );

    always_comb begin
        cfg_rdata                = '0;
        cfg_rdata[CFG_EN_BIT]    = mcfg.enable;
        cfg_rdata[CFG_TRIG_BIT]  = mcfg.trig;
        cfg_rdata[CFG_NMASK_BIT] = nm_mask;
    end

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> cfg_rdata[CFG_EN_BIT]); // R2
    AST_NMI_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> !cfg_rdata[CFG_NMASK_BIT]); // R7

endmodule

// File: tb/xint_ctrl_bench.sv
`timescale 1ns/1ps
module xint_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_pin_n = 1'b1;
    logic       nmi_pin_n = 1'b1;
    logic       cpu_imask = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       nm_wr = 1'b0;
    logic       nm_wdata = 1'b1;
    logic       irq_ack = 1'b0;
    logic       nmi_ack = 1'b0;
    logic       irq_req;
    logic       nmi_req;
    logic [2:0] cfg_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xint_ctrl u_xint_ctrl (
        .clk(clk), .rst(rst),
        .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
        .cpu_imask(cpu_imask),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .nm_wr(nm_wr), .nm_wdata(nm_wdata),
        .irq_ack(irq_ack), .nmi_ack(nmi_ack),
        .irq_req(irq_req), .nmi_req(nmi_req), .cfg_rdata(cfg_rdata)
    );

    // Cycle reference built from the requirements
    logic m_s1, m_s2, m_prev, m_en, m_trig, m_pend;
    logic n_s1, n_s2, n_prev, m_nmask, m_npend;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1; m_s2 <= 1; m_prev <= 1; m_en <= 0; m_trig <= 0; m_pend <= 0;
            n_s1 <= 1; n_s2 <= 1; n_prev <= 1; m_nmask <= 1; m_npend <= 0;
        end else begin
            m_s1 <= irq_pin_n; m_s2 <= m_s1; m_prev <= m_s2;
            n_s1 <= nmi_pin_n; n_s2 <= n_s1; n_prev <= n_s2;
            if (cfg_wr) begin m_en <= cfg_wdata[0]; m_trig <= cfg_wdata[1]; end
            if (!m_en || !m_trig)       m_pend <= 0;
            else if (m_prev && !m_s2)   m_pend <= 1;
            else if (irq_ack)           m_pend <= 0;
            if (nm_wr && !nm_wdata)     m_nmask <= 0;
            if (m_nmask)                m_npend <= 0;
            else if (n_prev && !n_s2)   m_npend <= 1;
            else if (nmi_ack)           m_npend <= 0;
        end
    end

    function automatic logic exp_irq();
        return m_en & ~cpu_imask & (m_trig ? m_pend : ~m_s2);
    endfunction

    function automatic logic exp_nmi();
        return ~m_nmask & m_npend;
    endfunction

    function automatic logic [2:0] exp_rd();
        return {m_nmask, m_trig, m_en};
    endfunction

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: the edge, then compare half a cycle later; the caller drives at negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
        check({2'b0, irq_req}, {2'b0, exp_irq()}, m_trig ? "R4 irq edge" : "R3 irq level");
        check({2'b0, nmi_req}, {2'b0, exp_nmi()}, "R9 nmi");
        check(cfg_rdata, exp_rd(), "R10 rdata");
    endtask

    task automatic wcfg(input logic [1:0] v);
        cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
    endtask

    task automatic wnm(input logic v);
        nm_wr = 1; nm_wdata = v; tick(); nm_wr = 0;
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check(cfg_rdata, 3'b100, "R1 reset config");
        check({irq_req, nmi_req}, 3'b0, "R1 reset outputs");

        // Level mode: R3
        wcfg(2'b01);
        irq_pin_n = 0; tick();
        check({2'b0, irq_req}, 3'd0, "R3 one edge not yet");
        tick();
        check({2'b0, irq_req}, 3'd1, "R3 level after two edges");
        irq_pin_n = 1; tick(); tick();
        check({2'b0, irq_req}, 3'd0, "R3 level released");

        // Edge mode: R4, R2
        wcfg(2'b11);
        irq_pin_n = 0; tick(); tick();
        check({2'b0, irq_req}, 3'd0, "R4 before third edge");
        tick();
        check({2'b0, irq_req}, 3'd1, "R4 latched");
        irq_pin_n = 1; tick(); tick();
        check({2'b0, irq_req}, 3'd1, "R4 held after pin release");
        cpu_imask = 1; #0.5;
        check({2'b0, irq_req}, 3'd0, "R2 cpu mask blocks");
        cpu_imask = 0; #0.5;
        check({2'b0, irq_req}, 3'd1, "R2 cpu mask lifted");

        // R5: ack with a simultaneous new edge keeps the latch
        irq_pin_n = 0; tick(); tick();
        irq_ack = 1; tick(); irq_ack = 0;
        check({2'b0, irq_req}, 3'd1, "R5 edge wins over ack");
        irq_ack = 1; tick(); irq_ack = 0;
        check({2'b0, irq_req}, 3'd0, "R5 ack clears");
        irq_pin_n = 1; tick(); tick();

        // R6: disable withdraws and empties the latch
        irq_pin_n = 0; tick(); tick(); tick();
        check({2'b0, irq_req}, 3'd1, "R6 setup pending");
        wcfg(2'b10);
        check({2'b0, irq_req}, 3'd0, "R6 disable drops request");
        wcfg(2'b11);
        check({2'b0, irq_req}, 3'd0, "R6 latch emptied");
        irq_pin_n = 1; tick(); tick();

        // R7: masked NMI edges discarded
        nmi_pin_n = 0; repeat (4) tick();
        check({2'b0, nmi_req}, 3'd0, "R7 masked nmi");
        wnm(1'b0);
        check({2'b0, nmi_req}, 3'd0, "R7 old edge dropped");
        check({2'b0, cfg_rdata[2]}, 3'd0, "R8 mask cleared");
        wnm(1'b1);
        check({2'b0, cfg_rdata[2]}, 3'd0, "R8 write of 1 ignored");

        // R9
        nmi_pin_n = 1; tick(); tick();
        nmi_pin_n = 0; tick(); tick();
        check({2'b0, nmi_req}, 3'd0, "R9 before third edge");
        tick();
        check({2'b0, nmi_req}, 3'd1, "R9 raised");
        nmi_ack = 1; tick(); nmi_ack = 0;
        check({2'b0, nmi_req}, 3'd0, "R9 ack clears");
        nmi_pin_n = 1; tick(); tick();

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 5) == 0) irq_pin_n = ~irq_pin_n;
            if ($urandom_range(0, 5) == 0) nmi_pin_n = ~nmi_pin_n;
            cpu_imask = ($urandom_range(0, 3) == 0);
            cfg_wr    = ($urandom_range(0, 19) == 0);
            cfg_wdata = 2'($urandom_range(0, 3));
            irq_ack   = ($urandom_range(0, 7) == 0);
            nmi_ack   = ($urandom_range(0, 7) == 0);
            nm_wr     = ($urandom_range(0, 29) == 0);
            nm_wdata  = ($urandom_range(0, 3) != 0);
            if (k == 2000) do_reset();
            tick();
        end
        cfg_wr = 0; irq_ack = 0; nmi_ack = 0; nm_wr = 0;

        // R8: only reset sets the mask again
        wnm(1'b0);
        do_reset();
        check({2'b0, cfg_rdata[2]}, 3'd1, "R8 reset sets mask");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule